// File: doc/BRIEF.md
# Register Scoreboard Issue Interlock

This block tracks, for every architectural register, whether its current contents can be trusted, and decides each cycle which of the instructions offered at the front of an in-order, multi-lane issue stage may go. A register becomes untrusted when an instruction that will write it issues. It becomes trusted again when a functional unit reports, through one of the completion ports, that the result has been written. Lane 0 always holds the oldest offered instruction. A lane is granted only when every older lane in the same group is granted too.

An instruction is held back for any of four reasons. One of its sources is untrusted. Its destination still has a write outstanding. An older lane in the same group writes a register that it reads or writes. A lane ahead of it is held. A completion that arrives in the same cycle counts as making its register trusted for that cycle's decision, so a dependent instruction can go without waiting a cycle. Register 0 is a constant register: it is always trusted and never tracked.

The grant outputs are combinational from the offered instructions, the completion ports and the registered table. The table updates on the next rising clock edge.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every bit of `reg_ready` is 1 (bit n describes register n).
- R2: A lane whose source register has its ready bit at 0, with no completion to that register in the same cycle, is not granted.
- R3: When a lane is granted with a nonzero destination, that register's `reg_ready` bit reads 0 from the next cycle on.
- R4: A completion port with its valid bit set makes the named register's `reg_ready` bit 1 from the next cycle on, unless R10 applies.
- R5: A lane whose nonzero destination has its ready bit at 0, with no completion to it in the same cycle, is not granted.
- R6: A completion to a register in a given cycle lets a lane that reads it, or writes it, be granted in that same cycle.
- R7: Grants are in order: lane i is granted only if lane i-1 is granted, so a held lane blocks every later lane even when those are ready.
- R8: A lane that reads or writes the nonzero destination of an older lane in the same group is not granted in that cycle.
- R9: Register 0 is always ready. A destination of 0 never blocks a grant and never clears bit 0.
- R10: When, in one cycle, a completion and a granted lane name the same destination, the register reads not ready in the next cycle.
- R11: Both completion ports may set different registers in the same cycle. Naming the same register on both ports in one cycle is illegal input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_req | input | LANES | Lane holds an instruction offered for issue (lane 0 oldest) |
| iss_src_a | input | LANES*RW | First source register number per lane |
| iss_src_b | input | LANES*RW | Second source register number per lane |
| iss_dst | input | LANES*RW | Destination register number per lane (0 = none) |
| cpl_vld | input | NCPL | Completion port reports a finished write |
| cpl_reg | input | NCPL*RW | Register number written by each completion port |
| iss_grant | output | LANES | Lane is issued this cycle |
| reg_ready | output | NREG | Ready bit per register |

## Verification
On every cycle, the assertions check several properties. No lane is granted past a held older lane. No granted lane reads an untrusted source or writes a register with a write outstanding, unless a completion to that register arrives in the same cycle. A granted destination reads not ready in the following cycle. A completion that no grant overrides reads ready in the following cycle. Register 0 stays ready, and the two completion ports never name the same register. The directed scenarios are needed to show the rest. They cover the reset contents, the blocking of a ready instruction behind a stalled one, the blocking caused by a dependency between lanes of one group, and the exact table contents after mixed grants and completions.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int SB_NREG  = 8;
    localparam int SB_LANES = 2;
    localparam int SB_NCPL  = 2;

    // Per-lane outcome of the readiness check.
    typedef struct packed {
        logic src_a_ok;
        logic src_b_ok;
        logic dst_ok;
    } lane_chk_t;

endpackage

// File: rtl/sb_cpl_decode.sv
// Turns the completion ports into a mask of registers set this cycle.
module sb_cpl_decode #(
    parameter int NREG = sb_pkg::SB_NREG,
    parameter int NCPL = sb_pkg::SB_NCPL,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [NCPL-1:0]    cpl_vld,
    input  logic [NCPL*RW-1:0] cpl_reg,
    output logic [NREG-1:0]    set_mask
);

    logic [NREG-1:0] port_mask [NCPL];

    for (genvar k = 0; k < NCPL; k++) begin : g_port
        always_comb begin
            port_mask[k] = '0;
            if (cpl_vld[k]) begin
                port_mask[k][cpl_reg[k*RW +: RW]] = 1'b1;
            end
        end
    end

    always_comb begin
        set_mask = '0;
        for (int k = 0; k < NCPL; k++) begin
            set_mask = set_mask | port_mask[k];
        end
    end

endmodule

// File: rtl/sb_lane_check.sv
// Readiness check of one lane against the effective table and older lanes.
module sb_lane_check
    import sb_pkg::*;
#(
    parameter int NREG = sb_pkg::SB_NREG,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] ready_eff,
    input  logic [NREG-1:0] older_dst,
    input  logic [RW-1:0]   src_a,
    input  logic [RW-1:0]   src_b,
    input  logic [RW-1:0]   dst,
    output lane_chk_t       chk,
    output logic            ok
);

    always_comb begin
        chk.src_a_ok = ready_eff[src_a] && !older_dst[src_a];
        chk.src_b_ok = ready_eff[src_b] && !older_dst[src_b];
        chk.dst_ok   = ready_eff[dst]   && !older_dst[dst];
        ok           = chk.src_a_ok && chk.src_b_ok && chk.dst_ok;
    end

endmodule

// File: rtl/sb_issue_chain.sv
// In-order grant chain: a lane goes only behind a granted older lane.
module sb_issue_chain #(
    parameter int LANES = sb_pkg::SB_LANES
) (
    input  logic [LANES-1:0] req,
    input  logic [LANES-1:0] ok,
    output logic [LANES-1:0] grant
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_head
            assign grant[i] = req[i] && ok[i];
        end else begin : g_tail
            assign grant[i] = req[i] && ok[i] && grant[i-1];
        end
    end

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG  = sb_pkg::SB_NREG,
    parameter int LANES = sb_pkg::SB_LANES,
    parameter int NCPL  = sb_pkg::SB_NCPL,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    iss_req,
    input  logic [LANES*RW-1:0] iss_src_a,
    input  logic [LANES*RW-1:0] iss_src_b,
    input  logic [LANES*RW-1:0] iss_dst,
    input  logic [NCPL-1:0]     cpl_vld,
    input  logic [NCPL*RW-1:0]  cpl_reg,
    output logic [LANES-1:0]    iss_grant,
    output logic [NREG-1:0]     reg_ready
);

    typedef struct packed {
        logic [NREG-1:0] valid;
    } sb_state_t;

    sb_state_t state_d, state_q;

    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] ready_eff;
    logic [NREG-1:0] dst_dec   [LANES];
    logic [NREG-1:0] older_dst [LANES];
    logic [NREG-1:0] clr_mask;
    logic [LANES-1:0] lane_ok;
    lane_chk_t       lane_chk  [LANES];

    sb_cpl_decode #(.NREG(NREG), .NCPL(NCPL)) u_cpl (
        .cpl_vld  (cpl_vld),
        .cpl_reg  (cpl_reg),
        .set_mask (set_mask)
    );

    assign ready_eff = state_q.valid | set_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Destination decode; register 0 is never tracked.
        always_comb begin
            dst_dec[i] = '0;
            dst_dec[i][iss_dst[i*RW +: RW]] = 1'b1;
            dst_dec[i][0] = 1'b0;
        end

        if (i == 0) begin : g_first
            assign older_dst[i] = '0;
        end else begin : g_next
            assign older_dst[i] = older_dst[i-1] | dst_dec[i-1];
        end

        sb_lane_check #(.NREG(NREG)) u_chk (
            .ready_eff (ready_eff),
            .older_dst (older_dst[i]),
            .src_a     (iss_src_a[i*RW +: RW]),
            .src_b     (iss_src_b[i*RW +: RW]),
            .dst       (iss_dst[i*RW +: RW]),
            .chk       (lane_chk[i]),
            .ok        (lane_ok[i])
        );
    end

    sb_issue_chain #(.LANES(LANES)) u_chain (
        .req   (iss_req),
        .ok    (lane_ok),
        .grant (iss_grant)
    );

    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < LANES; i++) begin
            if (iss_grant[i]) begin
                clr_mask = clr_mask | dst_dec[i];
            end
        end
    end

    // Next state: completions set, grants clear (clear wins), reg 0 pinned.
    always_comb begin
        state_d       = state_q;
        state_d.valid = (state_q.valid | set_mask) & ~clr_mask;
        state_d.valid[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.valid <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_ready = state_q.valid;

endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk #(
    parameter int NREG  = sb_pkg::SB_NREG,
    parameter int LANES = sb_pkg::SB_LANES,
    parameter int NCPL  = sb_pkg::SB_NCPL,
    localparam int RW   = $clog2(NREG)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [LANES-1:0]    iss_req,
    input logic [LANES*RW-1:0] iss_src_a,
    input logic [LANES*RW-1:0] iss_src_b,
    input logic [LANES*RW-1:0] iss_dst,
    input logic [NCPL-1:0]     cpl_vld,
    input logic [NCPL*RW-1:0]  cpl_reg,
    input logic [LANES-1:0]    iss_grant,
    input logic [NREG-1:0]     reg_ready
);

    logic [NREG-1:0] cpl_hit;
    logic [NREG-1:0] grant_dst;

    always_comb begin
        cpl_hit   = '0;
        grant_dst = '0;
        for (int k = 0; k < NCPL; k++) begin
            if (cpl_vld[k]) cpl_hit[cpl_reg[k*RW +: RW]] = 1'b1;
        end
        for (int i = 0; i < LANES; i++) begin
            if (iss_grant[i] && iss_dst[i*RW +: RW] != '0)
                grant_dst[iss_dst[i*RW +: RW]] = 1'b1;
        end
    end

    AST_REG0_READY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready[0]); // R9

    AST_CPL_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_vld[0] && cpl_vld[1] |-> cpl_reg[0 +: RW] != cpl_reg[RW +: RW]); // R11

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [RW-1:0] sa, sb, d;
        assign sa = iss_src_a[i*RW +: RW];
        assign sb = iss_src_b[i*RW +: RW];
        assign d  = iss_dst[i*RW +: RW];

        AST_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
            iss_grant[i] |-> (reg_ready[sa] || cpl_hit[sa]) && (reg_ready[sb] || cpl_hit[sb])); // R2

        AST_NO_WAW: assert property (@(posedge clk) disable iff (!rst_n)
            iss_grant[i] |-> reg_ready[d] || cpl_hit[d]); // R5

        AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            iss_grant[i] && d != '0 |=> !reg_ready[$past(d)]); // R3

        if (i > 0) begin : g_order
            AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                iss_grant[i] |-> iss_grant[i-1]); // R7
        end
    end

    for (genvar k = 0; k < NCPL; k++) begin : g_cpl
        logic [RW-1:0] r;
        assign r = cpl_reg[k*RW +: RW];

        AST_CPL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_vld[k] && !grant_dst[r] |=> reg_ready[$past(r)]); // R4
    end

endmodule

bind issue_scoreboard issue_scoreboard_chk #(
    .NREG(NREG), .LANES(LANES), .NCPL(NCPL)
) u_sb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_req   (iss_req),
    .iss_src_a (iss_src_a),
    .iss_src_b (iss_src_b),
    .iss_dst   (iss_dst),
    .cpl_vld   (cpl_vld),
    .cpl_reg   (cpl_reg),
    .iss_grant (iss_grant),
    .reg_ready (reg_ready)
);

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 8;
    localparam int LANES = 2;
    localparam int NCPL  = 2;
    localparam int RW    = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES-1:0]    iss_req = '0;
    logic [LANES*RW-1:0] iss_src_a = '0;
    logic [LANES*RW-1:0] iss_src_b = '0;
    logic [LANES*RW-1:0] iss_dst = '0;
    logic [NCPL-1:0]     cpl_vld = '0;
    logic [NCPL*RW-1:0]  cpl_reg = '0;
    logic [LANES-1:0]    iss_grant;
    logic [NREG-1:0]     reg_ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_scoreboard u_issue_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .iss_req(iss_req), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .cpl_vld(cpl_vld), .cpl_reg(cpl_reg),
        .iss_grant(iss_grant), .reg_ready(reg_ready)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus just after a falling edge.
    task automatic drive(input logic [1:0] req,
                         input logic [2:0] a0, input logic [2:0] b0, input logic [2:0] d0,
                         input logic [2:0] a1, input logic [2:0] b1, input logic [2:0] d1,
                         input logic [1:0] cv, input logic [2:0] c0, input logic [2:0] c1);
        @(negedge clk);
        iss_req   = req;
        iss_src_a = {a1, a0};
        iss_src_b = {b1, b0};
        iss_dst   = {d1, d0};
        cpl_vld   = cv;
        cpl_reg   = {c1, c0};
        #1;
    endtask

    task automatic idle();
        drive(2'b00, 0,0,0, 0,0,0, 2'b00, 0,0);
    endtask

    task automatic t_reset();
        idle();
        chk("R1 reset table", reg_ready, 8'hFF);
        chk("R1 no request no grant", {6'd0, iss_grant}, 8'h00);
    endtask

    task automatic t_clear_and_stall();
        drive(2'b01, 1,2,3, 0,0,0, 2'b00, 0,0);
        chk("R3 grant lane0", {6'd0, iss_grant}, 8'h01);
        idle();
        chk("R3 dst 3 stale", reg_ready, 8'hF7);
        drive(2'b01, 3,1,4, 0,0,0, 2'b00, 0,0);
        chk("R2 stale source held", {6'd0, iss_grant}, 8'h00);
        drive(2'b01, 1,1,3, 0,0,0, 2'b00, 0,0);
        chk("R5 pending dst held", {6'd0, iss_grant}, 8'h00);
        idle();
        chk("R2 table unchanged by stall", reg_ready, 8'hF7);
    endtask

    task automatic t_bypass();
        drive(2'b01, 3,1,4, 0,0,0, 2'b01, 3,0);
        chk("R6 bypass grant", {6'd0, iss_grant}, 8'h01);
        idle();
        chk("R6 reg3 set reg4 stale", reg_ready, 8'hEF);
        drive(2'b00, 0,0,0, 0,0,0, 2'b10, 0,4);
        idle();
        chk("R4 completion sets reg4", reg_ready, 8'hFF);
    endtask

    task automatic t_dual();
        drive(2'b11, 1,2,5, 3,4,6, 2'b00, 0,0);
        chk("R8 independent lanes both granted", {6'd0, iss_grant}, 8'h03);
        idle();
        chk("R3 two dsts stale", reg_ready, 8'h9F);
        drive(2'b00, 0,0,0, 0,0,0, 2'b11, 5,6);
        idle();
        chk("R11 two completions", reg_ready, 8'hFF);
    endtask

    task automatic t_in_order();
        drive(2'b01, 1,1,2, 0,0,0, 2'b00, 0,0);
        idle();
        chk("R3 reg2 stale", reg_ready, 8'hFB);
        drive(2'b11, 2,1,3, 4,5,6, 2'b00, 0,0);
        chk("R7 held lane0 blocks lane1", {6'd0, iss_grant}, 8'h00);
        idle();
        chk("R7 nothing issued", reg_ready, 8'hFB);
        drive(2'b00, 0,0,0, 0,0,0, 2'b01, 2,0);
        idle();
        chk("R4 reg2 restored", reg_ready, 8'hFF);
    endtask

    task automatic t_group();
        drive(2'b11, 1,1,5, 5,2,3, 2'b00, 0,0);
        chk("R8 lane1 reads lane0 dst", {6'd0, iss_grant}, 8'h01);
        drive(2'b00, 0,0,0, 0,0,0, 2'b01, 5,0);
        drive(2'b11, 1,1,6, 2,3,6, 2'b00, 0,0);
        chk("R8 lane1 writes lane0 dst", {6'd0, iss_grant}, 8'h01);
        idle();
        chk("R8 only reg6 stale", reg_ready, 8'hBF);
        drive(2'b00, 0,0,0, 0,0,0, 2'b01, 6,0);
        idle();
        chk("R4 reg6 restored", reg_ready, 8'hFF);
    endtask

    task automatic t_zero();
        drive(2'b11, 0,0,0, 0,0,0, 2'b00, 0,0);
        chk("R9 dst 0 never blocks", {6'd0, iss_grant}, 8'h03);
        idle();
        chk("R9 reg0 stays ready", reg_ready, 8'hFF);
    endtask

    task automatic t_priority();
        drive(2'b01, 1,1,7, 0,0,0, 2'b00, 0,0);
        idle();
        chk("R3 reg7 stale", reg_ready, 8'h7F);
        drive(2'b01, 1,2,7, 0,0,0, 2'b01, 7,0);
        chk("R6 dst bypass grant", {6'd0, iss_grant}, 8'h01);
        idle();
        chk("R10 clear beats set", reg_ready, 8'h7F);
        drive(2'b00, 0,0,0, 0,0,0, 2'b10, 0,7);
        idle();
        chk("R4 reg7 restored", reg_ready, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clear_and_stall();
        t_bypass();
        t_dual();
        t_in_order();
        t_group();
        t_zero();
        t_priority();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule